// File: doc/BRIEF.md
# Relative Next-Address Program Counter

This block keeps the program counter of a small processor and decides, on every update, which instruction address is fetched next. By default the counter steps to the following instruction. When the control logic marks the current instruction as an unconditional jump, or as a conditional branch whose register comparison succeeds, the counter instead loads a target address. The target is formed by adding a signed offset from the instruction word to the address of the following instruction.

The control unit supplies two strobes. The first is a write enable, which lets the counter change on a clock edge. The second is a relative-select strobe, which allows the target path to be used at all. A two-bit class code tells the block which kind of instruction is in flight. Two full-width register values are compared for equality to resolve the two conditional branch kinds. All address arithmetic is done in the width of the counter and wraps around at the top of the address space.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0. Reset is asynchronous and active low.
- R2: On a clock edge with `pc_we` low, `pc_o` keeps its value, whatever the other inputs are.
- R3: On a clock edge with `pc_we` high and class code 2'b00 (sequential), `pc_o` becomes `pc_o`+1.
- R4: On a clock edge with `pc_we` high and `rel_sel` low, `pc_o` becomes `pc_o`+1 for every class code.
- R5: Class code 2'b01 (jump), with `pc_we` and `rel_sel` high, loads `pc_o`+1+S, where S is `ofs_i` read as a two's-complement value and sign-extended to the counter width. For example, +3 moves forward three instructions past the next one, and -5 moves back five.
- R6: Class code 2'b10 (branch on equal), with `pc_we` and `rel_sel` high, loads `pc_o`+1+S when `opa_i` equals `opb_i`. Otherwise it loads `pc_o`+1.
- R7: Class code 2'b11 (branch on not equal), with `pc_we` and `rel_sel` high, loads `pc_o`+1+S when `opa_i` differs from `opb_i`. Otherwise it loads `pc_o`+1.
- R8: The equality test covers all DATA_W bits, so a difference in the most significant bit (bit 19) alone counts as unequal.
- R9: All next-address sums wrap modulo 2^ADDR_W (1024). The step after 1023 is 0, and a negative offset from a low address lands near the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_we | input | 1 | Allows the counter to update on this edge |
| rel_sel | input | 1 | Allows the relative target path |
| cls_i | input | 2 | Instruction class: 00 sequential, 01 jump, 10 branch on equal, 11 branch on not equal |
| ofs_i | input | OFS_W (8) | Signed relative offset from the instruction |
| opa_i | input | DATA_W (20) | First register value to compare |
| opb_i | input | DATA_W (20) | Second register value to compare |
| pc_o | output | ADDR_W (10) | Current program counter |

## Verification
Jumps are driven with small positive and negative offsets and with the two extreme offsets, +127 and -128. This shows that the offset is sign-extended and is added to the following address rather than the current one. Each branch kind is driven once with equal operands and once with unequal operands, which shows that the taken and not-taken paths are not swapped between the two branch kinds. One operand pair differs only in its top bit, which exposes a compare that is narrower than the full register. Cases with `rel_sel` low or `pc_we` low, together with a wrap below 0 and above 1023, separate the gating strobes from the address arithmetic.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;

    typedef enum logic [1:0] {
        CLS_SEQ = 2'b00,
        CLS_JMP = 2'b01,
        CLS_BEQ = 2'b10,
        CLS_BNE = 2'b11
    } cls_e;

endpackage

// File: rtl/pcnu_eq.sv
module pcnu_eq #(
    parameter int W = 20
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         eq_o
);
    logic [W-1:0] diff;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign diff[i] = a_i[i] ^ b_i[i];
    end

    assign eq_o = ~|diff;
endmodule

// File: rtl/pcnu_tgt.sv
module pcnu_tgt #(
    parameter int ADDR_W = 10,
    parameter int OFS_W  = 8
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [ADDR_W-1:0] seq_o,
    output logic [ADDR_W-1:0] tgt_o
);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_x;

    if (EXT_W > 0) begin : g_ext
        assign ofs_x = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
    end else begin : g_trunc
        assign ofs_x = ofs_i[ADDR_W-1:0];
    end

    assign seq_o = pc_i + ADDR_W'(1);
    assign tgt_o = seq_o + ofs_x;
endmodule

// File: rtl/pcnu_pick.sv
module pcnu_pick
    import pcnu_pkg::*;
(
    input  logic [1:0] cls_i,
    input  logic       rel_sel,
    input  logic       eq_i,
    output logic       take_o
);
    logic want;

    always_comb begin
        unique case (cls_e'(cls_i))
            CLS_SEQ: want = 1'b0;
            CLS_JMP: want = 1'b1;
            CLS_BEQ: want = eq_i;
            CLS_BNE: want = ~eq_i;
            default: want = 1'b0;
        endcase
        take_o = want & rel_sel;
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcnu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 20,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_we,
    input  logic              rel_sel,
    input  logic [1:0]        cls_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [ADDR_W-1:0] pc_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } state_t;

    state_t            st_d, st_q;
    logic              eq;
    logic              take;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] tgt_addr;

    pcnu_eq #(.W(DATA_W)) u_eq (
        .a_i  (opa_i),
        .b_i  (opb_i),
        .eq_o (eq)
    );

    pcnu_tgt #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_tgt (
        .pc_i  (st_q.pc),
        .ofs_i (ofs_i),
        .seq_o (seq_addr),
        .tgt_o (tgt_addr)
    );

    pcnu_pick u_pick (
        .cls_i   (cls_i),
        .rel_sel (rel_sel),
        .eq_i    (eq),
        .take_o  (take)
    );

    always_comb begin
        st_d = st_q;
        if (pc_we) begin
            st_d.pc = take ? tgt_addr : seq_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;
endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 20,
    parameter int OFS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pc_we,
    input logic              rel_sel,
    input logic [1:0]        cls_i,
    input logic [OFS_W-1:0]  ofs_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic [ADDR_W-1:0] pc_o
);
    logic [ADDR_W-1:0] sx;
    logic [ADDR_W-1:0] exp_seq;
    logic [ADDR_W-1:0] exp_tgt;
    logic              same;

    assign sx      = ADDR_W'($signed(ofs_i));
    assign exp_seq = pc_o + ADDR_W'(1);
    assign exp_tgt = exp_seq + sx;
    assign same    = (opa_i == opb_i);

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> pc_o == '0); // R1

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> $stable(pc_o)); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we && cls_i == 2'b00 |=> pc_o == $past(exp_seq)); // R3

    AST_NO_REL: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we && !rel_sel |=> pc_o == $past(exp_seq)); // R4

    AST_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we && rel_sel && cls_i == 2'b01 |=> pc_o == $past(exp_tgt)); // R5

    AST_BEQ_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we && rel_sel && cls_i == 2'b10 && same |=> pc_o == $past(exp_tgt)); // R6

    AST_BEQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we && rel_sel && cls_i == 2'b10 && !same |=> pc_o == $past(exp_seq)); // R6

    AST_BNE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we && rel_sel && cls_i == 2'b11 && !same |=> pc_o == $past(exp_tgt)); // R7

    AST_BNE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we && rel_sel && cls_i == 2'b11 && same |=> pc_o == $past(exp_seq)); // R7

    AST_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we && rel_sel && cls_i == 2'b10 && (opa_i[DATA_W-1] != opb_i[DATA_W-1])
        |=> pc_o == $past(exp_seq)); // R8

    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we && cls_i == 2'b00 && (&pc_o) |=> pc_o == '0); // R9
endmodule

bind pc_next_unit pc_next_unit_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc_we   (pc_we),
    .rel_sel (rel_sel),
    .cls_i   (cls_i),
    .ofs_i   (ofs_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .pc_o    (pc_o)
);

// File: tb/sim_pc_next_unit.sv
module sim_pc_next_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_we = 1'b0;
    logic        rel_sel = 1'b0;
    logic [1:0]  cls_i = 2'b00;
    logic [7:0]  ofs_i = 8'h00;
    logic [19:0] opa_i = '0;
    logic [19:0] opb_i = '0;
    logic [9:0]  pc_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pc_next_unit u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .pc_we   (pc_we),
        .rel_sel (rel_sel),
        .cls_i   (cls_i),
        .ofs_i   (ofs_i),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .pc_o    (pc_o)
    );

    // Vector layout: cls(2) sel(1) we(1) ofs(8) a(20) b(20) expected pc(10)
    localparam logic [61:0] VEC [0:NV-1] = '{
        {2'b00, 1'b1, 1'b1, 8'h00, 20'h00000, 20'h00000, 10'd1},   // R3
        {2'b00, 1'b1, 1'b1, 8'h00, 20'h00000, 20'h00000, 10'd2},   // R3
        {2'b01, 1'b1, 1'b1, 8'h03, 20'h00000, 20'h00000, 10'd6},   // R5 forward
        {2'b01, 1'b1, 1'b1, 8'hFB, 20'h00000, 20'h00000, 10'd2},   // R5 back
        {2'b10, 1'b1, 1'b1, 8'h0A, 20'h00005, 20'h00005, 10'd13},  // R6 taken
        {2'b10, 1'b1, 1'b1, 8'h0A, 20'h00005, 20'h00006, 10'd14},  // R6 not taken
        {2'b11, 1'b1, 1'b1, 8'hFC, 20'h00001, 20'h00002, 10'd11},  // R7 taken
        {2'b11, 1'b1, 1'b1, 8'hFC, 20'h00007, 20'h00007, 10'd12},  // R7 not taken
        {2'b11, 1'b1, 1'b1, 8'h02, 20'h80000, 20'h00000, 10'd15},  // R8
        {2'b10, 1'b1, 1'b1, 8'h02, 20'h80000, 20'h00000, 10'd16},  // R8
        {2'b01, 1'b0, 1'b1, 8'h14, 20'h00000, 20'h00000, 10'd17},  // R4
        {2'b10, 1'b0, 1'b1, 8'h14, 20'h00009, 20'h00009, 10'd18},  // R4
        {2'b01, 1'b1, 1'b0, 8'h14, 20'h00000, 20'h00000, 10'd18},  // R2
        {2'b00, 1'b1, 1'b0, 8'h00, 20'h00000, 20'h00000, 10'd18},  // R2
        {2'b01, 1'b1, 1'b1, 8'h80, 20'h00000, 20'h00000, 10'd915}, // R9
        {2'b01, 1'b1, 1'b1, 8'h7F, 20'h00000, 20'h00000, 10'd19},  // R9
        {2'b11, 1'b1, 1'b1, 8'hEC, 20'h00003, 20'h00004, 10'd0},   // R7
        {2'b01, 1'b1, 1'b1, 8'hFF, 20'h00000, 20'h00000, 10'd0}    // R5
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 1:      return "R3";
            2, 3, 17:  return "R5";
            4, 5:      return "R6";
            6, 7, 16:  return "R7";
            8, 9:      return "R8";
            10, 11:    return "R4";
            12, 13:    return "R2";
            default:   return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pc actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] c, input logic s, input logic w,
                        input logic [7:0] o, input logic [19:0] a, input logic [19:0] b);
        cls_i = c; rel_sel = s; pc_we = w; ofs_i = o; opa_i = a; opb_i = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R1", pc_o, 10'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][61:60], VEC[i][59], VEC[i][58], VEC[i][57:50],
                 VEC[i][49:30], VEC[i][29:10]);
            check(tag_of(i), pc_o, VEC[i][9:0]);
        end
        // R9: backward wrap from 0, then forward wrap from 1023
        step(2'b01, 1'b1, 1'b1, 8'hFE, '0, '0);
        check("R9", pc_o, 10'd1023);
        step(2'b00, 1'b1, 1'b1, 8'h00, '0, '0);
        check("R9", pc_o, 10'd0);
        // R1: reset in the middle of a run
        step(2'b01, 1'b1, 1'b1, 8'h20, '0, '0);
        check("R5", pc_o, 10'd33);
        rst_n = 1'b0;
        #1;
        check("R1", pc_o, 10'd0);
        step(2'b01, 1'b1, 1'b1, 8'h20, '0, '0);
        check("R1", pc_o, 10'd0);
        rst_n = 1'b1;
        step(2'b00, 1'b0, 1'b1, 8'h00, '0, '0);
        check("R4", pc_o, 10'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule